// File: doc/BRIEF.md
# Word/Doubleword Shifter with Algebraic Carry

This block performs logical left, logical right and algebraic right shifts on 32-bit (word) or 64-bit (doubleword) operands. It also performs a combined operation that sign-extends the low word to 64 bits and then shifts it left. Internally every operation is a left rotate followed by a contiguous bit mask. Algebraic shifts then fill every bit outside the mask with the sign. Word operands live in the low 32 bits of the 64-bit source.

The shift amount comes either from a 6-bit immediate or from the low bits of a second register. When it comes from the register, one extra bit above the amount field marks an out-of-range shift. Such a shift clears a logical result and fills an algebraic result with the sign. An algebraic shift also produces a carry, which is set only when the source is negative and at least one 1 bit is shifted out. The carry is delivered on two identical outputs (full-width copy and 32-bit copy) together with a write enable. A 3-bit signed-comparison condition field is produced when the record bit is set.

All outputs are registered, so a result appears one clock after its request.

Top module: `shift_carry_unit`

## Requirements
- R1: While rst_n is low and after its release with no request, out_valid, ca_we, cr_we, ca, ca32, cr and result are all zero.
- R2: out_valid is high in the cycle after in_valid was high, and low in the cycle after in_valid was low. The outputs of a request are visible one clock after it.
- R3: op_sel 2'b00 (logical left): the doubleword result is src shifted left by n, and the word result is src[31:0] shifted left by n. Bits 63:32 of a word result are zero.
- R4: op_sel 2'b01 (logical right): the doubleword result is src shifted right by n with zero fill. The word result is src[31:0] shifted right with zero fill, and its bits 63:32 are zero.
- R5: With amt_from_imm=1, n is amt_imm[4:0] in word mode and amt_imm[5:0] in doubleword mode, and it is never out of range. With amt_from_imm=0, n is amt_reg[4:0] (word) or amt_reg[5:0] (doubleword). The range bit is amt_reg[5] (word) or amt_reg[6] (doubleword). All higher register bits have no effect.
- R6: When the range bit is 1, a logical shift returns zero and an algebraic shift returns 64 copies of the sign.
- R7: op_sel 2'b10 (algebraic right) fills all vacated positions with the sign. The sign is src[31] in word mode and src[63] in doubleword mode. For a word, bits 63:32 are also the sign.
- R8: For an algebraic shift, ca = sign AND (any 1 bit shifted out). Only the low word counts in word mode, and with the range bit set every source bit in scope counts. ca32 always equals ca.
- R9: ca_we is 1 exactly for a valid algebraic shift. For every other operation ca_we is 0 and ca/ca32 are 0.
- R10: op_sel 2'b11 sign-extends src[31:0] to 64 bits and shifts it left by amt_imm[5:0]. dword, amt_from_imm and amt_reg have no effect on it.
- R11: When rec_en is 1, cr_we is 1 and cr holds exactly one set bit: cr[2] if the 64-bit result is negative, cr[1] if it is positive, cr[0] if it is zero. When rec_en is 0, cr_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 00 left, 01 right logical, 10 right algebraic, 11 sign-extend-word then left |
| dword | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit |
| amt_from_imm | input | 1 | 1 takes the amount from amt_imm, 0 from amt_reg |
| amt_imm | input | 6 | Immediate shift amount |
| amt_reg | input | 64 | Register holding the shift amount and range bit |
| src | input | 64 | Source operand |
| rec_en | input | 1 | Request a condition field update |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shifted result |
| ca_we | output | 1 | Carry write enable |
| ca | output | 1 | Carry flag |
| ca32 | output | 1 | 32-bit copy of the carry flag |
| cr_we | output | 1 | Condition field write enable |
| cr | output | 3 | Condition field {negative, positive, zero} |

## Verification
Each result is stored in the output register, so a wrong rotate amount, a misplaced mask edge or a wrong sign pick shows up on result one clock after the request. A wrong amount rotates bits into the wrong positions, a bad mask edge leaves wrapped bits in place or clears valid ones, and a wrong sign gives the wrong fill. A carry that looks at the wrong window is set or cleared wrongly in the same cycle. The amounts aimed at are 0, the top amount of each width and the range bit, because mask edge errors show only there. Random vectors with random upper register bits cover the ignored fields.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_SLL = 2'b00,
        SHF_SRL = 2'b01,
        SHF_SRA = 2'b10,
        SHF_XSL = 2'b11
    } shf_op_e;

    localparam int CR_NEG = 2;
    localparam int CR_POS = 1;
    localparam int CR_ZER = 0;

endpackage

// File: rtl/shf_amount.sv
// Selects the effective shift amount and the out-of-range flag.
module shf_amount #(
    parameter int XLEN = 64,
    parameter int AW   = $clog2(XLEN)
) (
    input  logic [1:0]      op_i,
    input  logic            wide_i,
    input  logic            from_imm_i,
    input  logic [AW-1:0]   imm_i,
    input  logic [XLEN-1:0] reg_i,
    output logic [AW-1:0]   n_o,
    output logic            ovf_o
);
    import shf_pkg::*;

    logic [AW-1:0] sel;
    logic          unused_hi;

    assign unused_hi = ^reg_i[XLEN-1:AW+1];

    always_comb begin
        sel = from_imm_i ? imm_i : reg_i[AW-1:0];
        if (shf_op_e'(op_i) == SHF_XSL) begin
            n_o   = imm_i;
            ovf_o = 1'b0;
        end else if (wide_i) begin
            n_o   = sel;
            ovf_o = !from_imm_i && reg_i[AW];
        end else begin
            n_o   = {1'b0, sel[AW-2:0]};
            ovf_o = !from_imm_i && reg_i[AW-1];
        end
    end
endmodule

// File: rtl/shf_rotl.sv
// Logarithmic left rotator: one stage per amount bit.
module shf_rotl #(
    parameter int XLEN = 64,
    parameter int AW   = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din_i,
    input  logic [AW-1:0]   amt_i,
    output logic [XLEN-1:0] dout_o
);
    logic [XLEN-1:0] stg [AW+1];

    assign stg[0] = din_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stg[k+1] = amt_i[k]
            ? {stg[k][XLEN-1-S:0], stg[k][XLEN-1:XLEN-S]}
            : stg[k];
    end

    assign dout_o = stg[AW];
endmodule

// File: rtl/shf_mask.sv
// Contiguous mask: bit i set when lo <= i <= hi, cleared entirely by kill.
module shf_mask #(
    parameter int XLEN = 64,
    parameter int AW   = $clog2(XLEN)
) (
    input  logic [AW-1:0]   lo_i,
    input  logic [AW-1:0]   hi_i,
    input  logic            kill_i,
    output logic [XLEN-1:0] mask_o
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign mask_o[i] = !kill_i && (AW'(i) >= lo_i) && (AW'(i) <= hi_i);
    end
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit #(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic             dword,
    input  logic             amt_from_imm,
    input  logic [5:0]       amt_imm,
    input  logic [XLEN-1:0]  amt_reg,
    input  logic [XLEN-1:0]  src,
    input  logic             rec_en,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic             ca_we,
    output logic             ca,
    output logic             ca32,
    output logic             cr_we,
    output logic [2:0]       cr
);
    import shf_pkg::*;

    localparam int AW   = $clog2(XLEN);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            ca_we;
        logic            ca;
        logic            ca32;
        logic            cr_we;
        logic [2:0]      cr;
    } out_t;

    out_t out_d, out_q;

    shf_op_e         op;
    logic            wide;
    logic            is_left;
    logic            is_sra;
    logic [AW-1:0]   n;
    logic            ovf;
    logic [XLEN-1:0] operand;
    logic [AW-1:0]   rot_amt;
    logic [XLEN-1:0] rotated;
    logic [AW-1:0]   top_bit;
    logic [AW-1:0]   m_lo;
    logic [AW-1:0]   m_hi;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] scope;
    logic            sign;
    logic [XLEN-1:0] shaped;
    logic            carry;

    assign op      = shf_op_e'(op_sel);
    assign wide    = dword || (op == SHF_XSL);
    assign is_left = (op == SHF_SLL) || (op == SHF_XSL);
    assign is_sra  = (op == SHF_SRA);

    shf_amount #(.XLEN(XLEN), .AW(AW)) u_amount (
        .op_i       (op_sel),
        .wide_i     (wide),
        .from_imm_i (amt_from_imm),
        .imm_i      (amt_imm[AW-1:0]),
        .reg_i      (amt_reg),
        .n_o        (n),
        .ovf_o      (ovf)
    );

    // Word operands are duplicated in both halves so a full-width rotate
    // gives the 32-bit rotate in the low half.
    always_comb begin
        if (op == SHF_XSL)
            operand = {{HALF{src[HALF-1]}}, src[HALF-1:0]};
        else if (dword)
            operand = src;
        else
            operand = {src[HALF-1:0], src[HALF-1:0]};
    end

    assign rot_amt = is_left ? n : (AW'(0) - n);

    shf_rotl #(.XLEN(XLEN), .AW(AW)) u_rotl (
        .din_i  (operand),
        .amt_i  (rot_amt),
        .dout_o (rotated)
    );

    assign top_bit = wide ? AW'(XLEN-1) : AW'(HALF-1);
    assign m_lo    = is_left ? n : '0;
    assign m_hi    = is_left ? top_bit : (top_bit - n);

    shf_mask #(.XLEN(XLEN), .AW(AW)) u_mask (
        .lo_i   (m_lo),
        .hi_i   (m_hi),
        .kill_i (ovf),
        .mask_o (mask)
    );

    assign scope = wide ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    assign sign  = wide ? operand[XLEN-1] : src[HALF-1];

    always_comb begin
        shaped = rotated & mask;
        if (is_sra)
            shaped = shaped | ({XLEN{sign}} & ~mask);
        carry = is_sra && sign && (|(rotated & ~mask & scope));
    end

    always_comb begin
        out_d       = out_q;
        out_d.vld   = in_valid;
        out_d.ca_we = 1'b0;
        out_d.cr_we = 1'b0;
        if (in_valid) begin
            out_d.res   = shaped;
            out_d.ca_we = is_sra;
            out_d.ca    = carry;
            out_d.ca32  = carry;
            out_d.cr_we = rec_en;
            if (rec_en) begin
                out_d.cr         = '0;
                out_d.cr[CR_NEG] = shaped[XLEN-1];
                out_d.cr[CR_POS] = !shaped[XLEN-1] && (shaped != '0);
                out_d.cr[CR_ZER] = (shaped == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign result    = out_q.res;
    assign ca_we     = out_q.ca_we;
    assign ca        = out_q.ca;
    assign ca32      = out_q.ca32;
    assign cr_we     = out_q.cr_we;
    assign cr        = out_q.cr;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    cawe_only_sra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ca_we |-> $past(in_valid && op_sel == 2'b10));

    // R8
    carry_needs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_we && ca) |-> $past(dword ? src[XLEN-1] : src[HALF-1]));

    // R6
    ovf_logical_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel[1] && !amt_from_imm &&
         (dword ? amt_reg[AW] : amt_reg[AW-1])) |=> (result == '0));

    // R11
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr) == 1));

    // R3
    word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dword && !op_sel[1]) |=> (result[XLEN-1:HALF] == '0));
endmodule

// File: tb/shift_carry_unit_bench.sv
`timescale 1ns/1ps
module shift_carry_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        dword = 1'b0;
    logic        amt_from_imm = 1'b0;
    logic [5:0]  amt_imm = '0;
    logic [63:0] amt_reg = '0;
    logic [63:0] src = '0;
    logic        rec_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        ca_we, ca, ca32, cr_we;
    logic [2:0]  cr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    shift_carry_unit u_shift_carry_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .dword(dword), .amt_from_imm(amt_from_imm), .amt_imm(amt_imm),
        .amt_reg(amt_reg), .src(src), .rec_en(rec_en),
        .out_valid(out_valid), .result(result), .ca_we(ca_we), .ca(ca),
        .ca32(ca32), .cr_we(cr_we), .cr(cr)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected values from the requirements, using plain shift operators.
    function automatic void model(input logic [1:0] op, input logic dw,
                                  input logic ui, input logic [5:0] imm,
                                  input logic [63:0] ra, input logic [63:0] s,
                                  output logic [63:0] res, output logic cy);
        int          n;
        logic        ovf;
        logic        sg;
        logic [31:0] w;
        logic [63:0] x;
        cy = 1'b0;
        if (op == 2'b11) begin
            x   = {{32{s[31]}}, s[31:0]};
            res = x << imm;
        end else if (dw) begin
            n   = ui ? int'(imm) : int'(ra[5:0]);
            ovf = !ui && ra[6];
            sg  = s[63];
            case (op)
                2'b00: res = ovf ? 64'd0 : s << n;
                2'b01: res = ovf ? 64'd0 : s >> n;
                default: begin
                    res = ovf ? {64{sg}} : 64'($signed(s) >>> n);
                    cy  = sg && (ovf ? (|s) : (|(s & ((64'd1 << n) - 64'd1))));
                end
            endcase
        end else begin
            n   = ui ? int'(imm[4:0]) : int'(ra[4:0]);
            ovf = !ui && ra[5];
            w   = s[31:0];
            sg  = w[31];
            case (op)
                2'b00: res = ovf ? 64'd0 : {32'd0, w << n};
                2'b01: res = ovf ? 64'd0 : {32'd0, w >> n};
                default: begin
                    x   = {{32{sg}}, w};
                    res = ovf ? {64{sg}} : 64'($signed(x) >>> n);
                    cy  = sg && (ovf ? (|w) : (|({32'd0, w} & ((64'd1 << n) - 64'd1))));
                end
            endcase
        end
    endfunction

    task automatic run(input logic [1:0] op, input logic dw, input logic ui,
                       input logic [5:0] imm, input logic [63:0] ra,
                       input logic [63:0] s, input logic rec);
        logic [63:0] eres;
        logic        ecy;
        logic [2:0]  ecr;
        string       rtag;
        in_valid = 1'b1; op_sel = op; dword = dw; amt_from_imm = ui;
        amt_imm = imm; amt_reg = ra; src = s; rec_en = rec;
        model(op, dw, ui, imm, ra, s, eres, ecy);
        ecr = ($signed(eres) < 0) ? 3'b100 : (eres == 64'd0) ? 3'b001 : 3'b010;
        case (op)
            2'b00: rtag = "R3/R5/R6 left";
            2'b01: rtag = "R4/R5/R6 right";
            2'b10: rtag = "R7/R6 algebraic";
            default: rtag = "R10 extend-left";
        endcase
        @(posedge clk);
        @(negedge clk);
        check("R2 out_valid", {63'd0, out_valid}, 64'd1);
        check(rtag, result, eres);
        check("R9 ca_we", {63'd0, ca_we}, {63'd0, op == 2'b10});
        check("R8 ca", {63'd0, ca}, {63'd0, ecy});
        check("R8 ca32", {63'd0, ca32}, {63'd0, ecy});
        check("R11 cr_we", {63'd0, cr_we}, {63'd0, rec});
        if (rec) check("R11 cr", {61'd0, cr}, {61'd0, ecr});
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        check("R1 ca_we", {63'd0, ca_we}, 64'd0);
        check("R1 cr_we", {63'd0, cr_we}, 64'd0);
        check("R1 cr", {61'd0, cr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {62'd0, out_valid, ca}, 64'd0);

        // Directed corner cases
        run(2'b00, 1'b1, 1'b1, 6'd0,  64'd0, 64'h8000_0000_0000_0001, 1'b1);
        run(2'b00, 1'b1, 1'b0, 6'd0,  64'd63, 64'h0000_0000_0000_0003, 1'b1);
        run(2'b01, 1'b1, 1'b0, 6'd0,  64'd63, 64'h8000_0000_0000_0000, 1'b1);
        run(2'b00, 1'b0, 1'b0, 6'd0,  64'd31, 64'hFFFF_FFFF_0000_0003, 1'b1);
        run(2'b01, 1'b0, 1'b1, 6'd33, 64'd0,  64'h1234_5678_8000_0000, 1'b0);
        // R6: range bit set
        run(2'b00, 1'b0, 1'b0, 6'd0,  64'd32, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        run(2'b01, 1'b1, 1'b0, 6'd0,  64'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        run(2'b10, 1'b0, 1'b0, 6'd0,  64'd40, 64'h0000_0000_8000_0000, 1'b1);
        run(2'b10, 1'b0, 1'b0, 6'd0,  64'd40, 64'hFFFF_FFFF_7FFF_FFFF, 1'b1);
        run(2'b10, 1'b1, 1'b0, 6'd0,  64'd127, 64'h8000_0000_0000_0000, 1'b1);
        // R5: word ignores amt_reg bit 6 and above
        run(2'b00, 1'b0, 1'b0, 6'd0,  64'hFFFF_FF00_0000_00C4, 64'h0000_0000_0000_00F1, 1'b0);
        // R8: negative source, no ones lost vs ones lost
        run(2'b10, 1'b1, 1'b1, 6'd4,  64'd0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1);
        run(2'b10, 1'b1, 1'b1, 6'd4,  64'd0, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1);
        run(2'b10, 1'b0, 1'b1, 6'd31, 64'd0, 64'h0000_0001_8000_0000, 1'b1);
        run(2'b10, 1'b0, 1'b1, 6'd0,  64'd0, 64'h0000_0000_FFFF_FFFF, 1'b1);
        // R10: extend then shift left, dword/register ignored
        run(2'b11, 1'b0, 1'b0, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0001, 1'b1);
        run(2'b11, 1'b1, 1'b1, 6'd4,  64'd9, 64'hAAAA_AAAA_F000_000F, 1'b1);

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            logic [63:0] ra;
            logic [63:0] s;
            ra = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) ra[6:5] = 2'b00;
            s = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 0) s[63] = 1'b1;
            run(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                6'($urandom), ra, s, 1'($urandom));
        end

        // R2/R9: idle cycle drops valid and write enables
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R9 idle ca_we", {63'd0, ca_we}, 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule